// File: doc/BRIEF.md
# DSP Address Generation Unit

This block produces data memory addresses for a DSP datapath. It holds a small file of auxiliary address registers, two index registers and one block-size register. On an access, the address output shows the current value of the selected auxiliary register. On the clock edge that closes the access, that register is overwritten with a post-modified value chosen by the mode input.

The modes are:

- plain step up or down by one;
- add or subtract an index register;
- circular stepping inside a buffer whose length is held in the block-size register;
- reverse-carry addition of the first index register, which walks a power-of-two table in bit-reversed order for FFT operand ordering.

Every register is written through a single write port. A write aimed at the same auxiliary register as a post-modify in the same cycle takes priority.

Top module: `agu`

## Requirements
- R1: After reset every auxiliary, index and block-size register is zero, so `addr` reads 0 for every `sel`.
- R2: `addr` is combinational and equals the current (pre-modify) value of the auxiliary register picked by `sel`.
- R3: With `wr_en` high, `wr_data` is stored on the clock edge into the register named by `wr_sel`. Codes 0..7 select auxiliary registers, 8 the first index register (IDX0), 9 the second (IDX1), 10 the block size (BLK).
- R4: When a write and a post-modify target the same auxiliary register in one cycle, the written value is kept.
- R5: With `acc_en` low, or with mode code 0, no register changes.
- R6: Mode 1 adds one and mode 2 subtracts one, both modulo 2^16.
- R7: Mode 3 adds IDX0, mode 4 subtracts IDX0, and mode 5 adds IDX1, all modulo 2^16.
- R8: Mode 6 (circular) works within a window of size P, the smallest power of two at least BLK. The window base is the register with its low log2(P) bits cleared. The offset is those low bits. If offset+1 is at least BLK, the register returns to the base; otherwise it becomes base+offset+1.
- R9: In mode 6 with BLK equal to 0, the register simply adds one.
- R10: Mode 7 adds IDX0 with carries moving from the most significant bit toward the least significant bit; the carry out of bit 0 is discarded.
- R11: In mode 7 with IDX0 = N/2 (N a power of two), starting from an N-aligned base, N accesses visit base+bitrev(k) for k = 0..N-1, each exactly once, and then return to the base.
- R12: A post-modify changes only the selected auxiliary register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe; post-modify is applied on the edge when high |
| sel | input | 3 | Auxiliary register selected for the access |
| mode | input | 3 | Post-modify mode code 0..7 |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 4 | Register written (0..7 auxiliary, 8 IDX0, 9 IDX1, 10 BLK) |
| wr_data | input | 16 | Value written |
| addr | output | 16 | Current value of the selected auxiliary register |

## Verification
The bench targets the following weak points:

- Wrap at 0xFFFF and 0x0000. A design with a narrow or signed adder would step to the wrong value there.
- Every BLK value from 0 to 12, including one past a power of two. Here an off-by-one in the wrap test either overshoots the last buffer slot or wraps one step early.
- A start point already beyond the buffer length. This catches a design that lets the pointer escape the window.
- Bit-reversed walks over 8-, 16- and 32-entry tables. A normal-carry adder would produce a linear sequence and repeat or skip indices.
- Same-register write and access collisions. These expose a design whose update overrides the load.

// File: rtl/agu.sv
module agu #(
  parameter int AW = 16,
  parameter int NUM_AR = 8,
  localparam int SW = $clog2(NUM_AR),
  localparam int WSW = $clog2(NUM_AR + 3)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_en,
  input  logic [SW-1:0]  sel,
  input  logic [2:0]     mode,
  input  logic           wr_en,
  input  logic [WSW-1:0] wr_sel,
  input  logic [AW-1:0]  wr_data,
  output logic [AW-1:0]  addr
);
  localparam logic [2:0] M_NONE = 3'd0, M_INC = 3'd1, M_DEC = 3'd2, M_ADD0 = 3'd3,
                         M_SUB0 = 3'd4, M_ADD1 = 3'd5, M_CIRC = 3'd6, M_BREV = 3'd7;
  localparam logic [WSW-1:0] SEL_IDX0 = WSW'(NUM_AR);
  localparam logic [WSW-1:0] SEL_IDX1 = WSW'(NUM_AR + 1);
  localparam logic [WSW-1:0] SEL_BLK  = WSW'(NUM_AR + 2);

  logic [AW-1:0] ar_q [NUM_AR];
  logic [AW-1:0] ir0_r, ir1_r, bk_r;
  logic [AW-1:0] cur, nxt, win_mask, off, base, circ_nxt;
  logic [AW:0]   off_inc;

  function automatic logic [AW-1:0] rev(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  assign cur  = ar_q[sel];
  assign addr = cur;

  always_comb begin
    win_mask = bk_r - AW'(1);
    for (int i = 0; i < AW; i++) win_mask = win_mask | (win_mask >> 1);
  end

  assign off      = cur & win_mask;
  assign base     = cur & ~win_mask;
  assign off_inc  = {1'b0, off} + {{AW{1'b0}}, 1'b1};
  assign circ_nxt = (bk_r == '0) ? cur + AW'(1) :
                    (off_inc >= {1'b0, bk_r}) ? base : (base | off_inc[AW-1:0]);

  always_comb begin
    unique case (mode)
      M_NONE:  nxt = cur;
      M_INC:   nxt = cur + AW'(1);
      M_DEC:   nxt = cur - AW'(1);
      M_ADD0:  nxt = cur + ir0_r;
      M_SUB0:  nxt = cur - ir0_r;
      M_ADD1:  nxt = cur + ir1_r;
      M_CIRC:  nxt = circ_nxt;
      M_BREV:  nxt = rev(rev(cur) + rev(ir0_r));
      default: nxt = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_AR; i++) ar_q[i] <= '0;
      ir0_r <= '0;
      ir1_r <= '0;
      bk_r  <= '0;
    end else begin
      if (acc_en && mode != M_NONE) ar_q[sel] <= nxt;
      if (wr_en) begin
        if (wr_sel < SEL_IDX0) ar_q[wr_sel[SW-1:0]] <= wr_data;
        else if (wr_sel == SEL_IDX0) ir0_r <= wr_data;
        else if (wr_sel == SEL_IDX1) ir1_r <= wr_data;
        else if (wr_sel == SEL_BLK)  bk_r  <= wr_data;
      end
    end
  end
endmodule

module agu_chk #(
  parameter int AW = 16,
  parameter int NUM_AR = 8,
  localparam int SW = $clog2(NUM_AR),
  localparam int WSW = $clog2(NUM_AR + 3)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           acc_en,
  input logic [SW-1:0]  sel,
  input logic [2:0]     mode,
  input logic           wr_en,
  input logic [WSW-1:0] wr_sel,
  input logic [AW-1:0]  wr_data,
  input logic [AW-1:0]  addr,
  input logic [AW-1:0]  ir0_r
);
  logic hit;
  assign hit = wr_en && (wr_sel == WSW'(sel));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel < WSW'(NUM_AR)) |=>
      (sel != $past(wr_sel[SW-1:0])) || (addr == $past(wr_data)));

  p_load_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && acc_en) |=> (sel != $past(sel)) || (addr == $past(wr_data)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && (!acc_en || mode == 3'd0)) |=> (sel != $past(sel)) || $stable(addr));

  p_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && acc_en && mode == 3'd1) |=> (sel != $past(sel)) || (addr == $past(addr) + AW'(1)));

  p_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && acc_en && mode == 3'd2) |=> (sel != $past(sel)) || (addr == $past(addr) - AW'(1)));

  p_add_idx0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && acc_en && mode == 3'd3) |=> (sel != $past(sel)) || (addr == $past(addr) + $past(ir0_r)));
endmodule

bind agu agu_chk #(.AW(AW), .NUM_AR(NUM_AR)) chk_i (.*);

// File: tb/agu_tb.sv
module agu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0;
  logic [2:0]  sel = '0;
  logic [2:0]  mode = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] addr;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] m_ar [8];
  logic [15:0] m_ir0 = 0, m_ir1 = 0, m_bk = 0;

  agu dut_i (.clk(clk), .rst_n(rst_n), .acc_en(acc_en), .sel(sel), .mode(mode),
             .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .addr(addr));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] rv(input logic [15:0] v);
    logic [15:0] r = 0;
    for (int i = 0; i < 16; i++) if (v[i]) r[15-i] = 1'b1;
    return r;
  endfunction

  function automatic logic [15:0] brk(input int k, input int bits);
    int r = 0;
    for (int i = 0; i < bits; i++) if ((k >> i) & 1) r = r | (1 << (bits - 1 - i));
    return 16'(r);
  endfunction

  function automatic logic [15:0] model_next(input logic [15:0] a, input int md);
    int p, off, bs;
    case (md)
      1: return a + 16'd1;
      2: return a - 16'd1;
      3: return a + m_ir0;
      4: return a - m_ir0;
      5: return a + m_ir1;
      6: begin
        if (m_bk == 0) return a + 16'd1;
        p = 1;
        while (p < int'(m_bk)) p = p * 2;
        off = int'(a) % p;
        bs = int'(a) - off;
        if (off + 1 >= int'(m_bk)) return 16'(bs);
        return 16'(bs + off + 1);
      end
      7: return rv(rv(a) + rv(m_ir0));
      default: return a;
    endcase
  endfunction

  task automatic wr(input int idx, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = 4'(idx); wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    if (idx < 8) m_ar[idx] = d;
    else if (idx == 8) m_ir0 = d;
    else if (idx == 9) m_ir1 = d;
    else if (idx == 10) m_bk = d;
  endtask

  task automatic peek(input int s, input string req);
    sel = 3'(s); #1;
    check(req, addr, m_ar[s]);
  endtask

  task automatic acc(input int s, input int md, input string req);
    sel = 3'(s); mode = 3'(md); acc_en = 1'b1; #1;
    check("R2", addr, m_ar[s]);
    @(posedge clk); @(negedge clk);
    acc_en = 1'b0;
    m_ar[s] = model_next(m_ar[s], md);
    peek(s, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 8; s++) begin m_ar[s] = 0; peek(s, "R1"); end

    for (int s = 0; s < 8; s++) wr(s, 16'(s * 16'h1111 + 3));
    for (int s = 0; s < 8; s++) peek(s, "R3");
    wr(8, 16'h0123); wr(9, 16'hFFF0);

    for (int md = 0; md < 6; md++)
      for (int s = 0; s < 8; s++) begin
        acc(s, md, md == 0 ? "R5" : (md < 3 ? "R6" : "R7"));
        peek((s + 1) % 8, "R12");
      end

    wr(0, 16'hFFFF); acc(0, 1, "R6");
    wr(1, 16'h0000); acc(1, 2, "R6");
    wr(2, 16'h0005); acc(2, 4, "R7");

    sel = 3'd4; mode = 3'd1; acc_en = 1'b0;
    @(posedge clk); @(negedge clk);
    peek(4, "R5");

    for (int s = 0; s < 8; s += 3) begin
      sel = 3'(s); mode = 3'd1; acc_en = 1'b1;
      wr_en = 1'b1; wr_sel = 4'(s); wr_data = 16'(16'hA500 + s);
      @(posedge clk); @(negedge clk);
      acc_en = 1'b0; wr_en = 1'b0;
      m_ar[s] = 16'(16'hA500 + s);
      peek(s, "R4");
    end

    for (int b = 1; b <= 12; b++) begin
      wr(10, 16'(b));
      wr(2, 16'h0040);
      for (int k = 0; k < 2 * b + 1; k++) acc(2, 6, "R8");
      peek(5, "R12");
    end
    wr(10, 16'd5); wr(2, 16'h0047); acc(2, 6, "R8");
    wr(10, 16'd0); wr(2, 16'h00FF); acc(2, 6, "R9"); acc(2, 6, "R9");

    wr(8, 16'h0005); wr(6, 16'h1234);
    for (int k = 0; k < 6; k++) acc(6, 7, "R10");
    wr(8, 16'h8001); acc(6, 7, "R10");

    for (int lg = 3; lg <= 5; lg++) begin
      int n = 1 << lg;
      bit seen [32];
      for (int i = 0; i < 32; i++) seen[i] = 0;
      wr(8, 16'(n / 2));
      wr(3, 16'h0100);
      for (int k = 0; k <= n; k++) begin
        sel = 3'd3; #1;
        check("R11", addr, 16'h0100 + brk(k % n, lg));
        if (k < n) begin
          if (seen[int'(addr) & (n - 1)]) begin
            fails++;
            $display("FAIL R11: index %0d revisited, expected once", int'(addr) & (n - 1));
          end
          vectors++;
          seen[int'(addr) & (n - 1)] = 1;
        end
        mode = 3'd7; acc_en = 1'b1;
        @(posedge clk); @(negedge clk);
        acc_en = 1'b0;
        m_ar[3] = model_next(m_ar[3], 7);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule